// File: doc/BRIEF.md
# Two-Channel Converter Serial Output Port

This block is the device-side digital port of a two-channel sensor converter. A timer stands in for the conversion engine: each conversion lasts a fixed number of system clock cycles. When it ends, the block latches a 28-bit sample value together with a sign flag, an out-of-range flag and the tag of the channel that was converted. The channel alternates on every conversion, and channel 0 goes first after reset. Once a conversion is finished the block sleeps and keeps the result for as long as chip select stays high.

A host reads the result through an active-low chip select, a serial clock and a tri-state data line. While chip select is low and no transfer is running, the data line shows the conversion status in real time. The 32-bit frame is shifted out on falling clock edges. Raising chip select in the middle of a frame abandons that frame and starts a fresh conversion. The serial clock pin can run in two directions. Its level at reset and at every chip-select fall decides whether the host supplies the clock or the port generates it from a divided system clock. An external clock is brought through a synchroniser, so it must run at least four times slower than the system clock.

Top module: `adc_sout_port`

## Requirements
- R1: While chip select is high, sdo_en is 0 and sdo is 0, and serial clock edges do not move the frame position: a read that starts after such edges returns the complete frame from its first bit.
- R2: While chip select is low and no frame is in progress, sdo is 1 during a conversion and drops to 0 as soon as the result is held.
- R3: The frame is 32 bits, most significant first: bit 31 = 0 (conversion finished), bit 30 = channel (0 or 1), bit 29 = smp_sgn, bit 28 = smp_exr, bits 27..0 = smp_val (24 result bits then 4 sub-LSB bits), all latched when the conversion ends.
- R4: Bit 31 is on sdo before the first rising clock edge. Each later bit appears after a falling edge and stays through the following rising edge, so the 31st falling edge presents bit 0.
- R5: The 32nd falling edge drives sdo to 1 and starts a new conversion that lasts CONV_CYC system clock cycles.
- R6: A rise of chip select after the first rising clock edge of a frame abandons that frame and starts a new conversion; the abandoned result is not offered again.
- R7: A finished result is held for any length of time while chip select is high, and a chip-select fall followed by a rise with no clock edge between them leaves it in place.
- R8: The level of sck_in is sampled during reset and at each chip-select fall: 0 selects external clock (sck_drv = 0), 1 selects internal clock (sck_drv = 1). Changes of sck_in at any other time leave the mode unchanged.
- R9: In internal clock mode the port drives sck_out with a period of 2*SCK_HALF cycles, 32 pulses per frame, and sends the same frame as in R3.
- R10: The first conversion after reset uses channel 0, and every conversion, whether completed or abandoned, uses the other channel from the one before; ch_sel shows the channel of the next or current conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also the power-up clock-mode sampling window |
| cs_n | input | 1 | Active-low chip select (asynchronous, synchronised inside) |
| sck_in | input | 1 | Serial clock from the host in external mode; mode-select level |
| sck_out | output | 1 | Serial clock produced in internal mode |
| sck_drv | output | 1 | 1 when the port drives the serial clock pin |
| sdo | output | 1 | Serial data / conversion status |
| sdo_en | output | 1 | Output enable of the data line (0 = high impedance) |
| smp_val | input | 28 | Sample value from the conversion stand-in |
| smp_sgn | input | 1 | Sign of the sample (1 = positive) |
| smp_exr | input | 1 | Sample lies outside the normal range |
| ch_sel | output | 1 | Channel the conversion stand-in should convert |

## Verification
The bench builds the port with CONV_CYC = 40 and SCK_HALF = 3, so that one conversion plus a complete external-clock frame takes about 300 cycles. It can therefore sweep a walking one across all 28 value bits, together with every combination of the two flags, and track the channel alternation over dozens of conversions. The short conversion time also makes it possible to measure the conversion length to the cycle. Waits many times longer than a conversion are cheap to run, so sleep is covered as well. Both clock modes are switched at run time, and the internal pulse train is short enough to time each period.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;
  localparam int FRAME_W = 32;
  localparam int VAL_W   = 28;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_READY = 2'd1,
    ST_XFER  = 2'd2
  } port_st_e;

  // Frame layout: status flag (0 = done), channel, sign, range flag, value
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic             ch,
    input logic             sgn,
    input logic             exr,
    input logic [VAL_W-1:0] val
  );
    return {1'b0, ch, sgn, exr, val};
  endfunction
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    sh <= {sh[STAGES-1:0], d};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [HW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == HW'(HALF - 1));
  assign rise = wrap && !sck;
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sout_port.sv
module adc_sout_port
  import adc_sout_pkg::*;
#(
  parameter int CONV_CYC = 200,
  parameter int SCK_HALF = 4,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_drv,
  output logic             sdo,
  output logic             sdo_en,
  input  logic [VAL_W-1:0] smp_val,
  input  logic             smp_sgn,
  input  logic             smp_exr,
  output logic             ch_sel
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  // synchronised pins and their edges
  logic cs_lvl, cs_rise, cs_fall;
  logic sck_lvl, xsck_rise, xsck_fall;

  adc_sync_edge #(.STAGES(SYNC_STG)) u_cs_sync (
    .clk(clk), .d(cs_n), .lvl(cs_lvl), .rise(cs_rise), .fall(cs_fall)
  );
  adc_sync_edge #(.STAGES(SYNC_STG)) u_sck_sync (
    .clk(clk), .d(sck_in), .lvl(sck_lvl), .rise(xsck_rise), .fall(xsck_fall)
  );

  // named internal events
  port_st_e          state;
  logic [CNT_W-1:0]  fcnt;
  logic [FRAME_W-1:0] frame_q;
  logic              cur_ch;
  logic              int_mode;
  logic              cs_low;
  logic              conv_run;
  logic              conv_done;
  logic              gen_en, gen_rise, gen_fall;
  logic              sh_rise, sh_fall;
  logic              held_ch;
  logic              sdo_bit;

  assign cs_low   = !cs_lvl;
  assign conv_run = (state == ST_CONV);
  assign held_ch  = frame_q[FRAME_W-2];

  // clock mode: loads during reset and on every chip-select fall
  always_ff @(posedge clk) begin
    if (!rst_n || cs_fall) int_mode <= sck_lvl;
  end

  adc_conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(conv_run), .done(conv_done)
  );

  assign gen_en = int_mode && cs_low && (state != ST_CONV);

  adc_sck_gen #(.HALF(SCK_HALF)) u_sck_gen (
    .clk(clk), .rst_n(rst_n), .en(gen_en),
    .sck(sck_out), .rise(gen_rise), .fall(gen_fall)
  );

  assign sh_rise = int_mode ? gen_rise : (cs_low && xsck_rise);
  assign sh_fall = int_mode ? gen_fall : (cs_low && xsck_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CONV;
      fcnt    <= '0;
      frame_q <= '0;
      cur_ch  <= 1'b0;
    end else begin
      unique case (state)
        ST_CONV: begin
          if (conv_done) begin
            frame_q <= pack_frame(cur_ch, smp_sgn, smp_exr, smp_val);
            cur_ch  <= ~cur_ch;
            state   <= ST_READY;
          end
        end
        ST_READY: begin
          if (cs_low && sh_rise) begin
            fcnt  <= '0;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (cs_rise) begin
            state <= ST_CONV;
          end else if (sh_fall) begin
            if (fcnt == LAST_BIT) begin
              fcnt  <= '0;
              state <= ST_CONV;
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_CONV:  sdo_bit = 1'b1;
      ST_READY: sdo_bit = 1'b0;
      ST_XFER:  sdo_bit = frame_q[LAST_BIT - fcnt];
      default:  sdo_bit = 1'b1;
    endcase
  end

  assign sdo_en  = cs_low;
  assign sdo     = cs_low & sdo_bit;
  assign sck_drv = int_mode;
  assign ch_sel  = cur_ch;
endmodule

// File: rtl/adc_sout_chk.sv
module adc_sout_chk
  import adc_sout_pkg::*;
#(
  parameter int CONV_CYC = 200
) (
  input logic             clk,
  input logic             rst_n,
  input port_st_e         st,
  input logic             sdo,
  input logic             sdo_en,
  input logic             conv_run,
  input logic             conv_done,
  input logic             cur_ch,
  input logic             held_ch,
  input logic             cs_low,
  input logic             cs_rise,
  input logic             cs_fall,
  input logic             int_mode,
  input logic [CNT_W-1:0] fcnt
);
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_cnt <= 0;
    else if (conv_run && !conv_done) run_cnt <= run_cnt + 1;
    else                             run_cnt <= 0;
  end

  // R1
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  // R1
  cs_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> $stable(fcnt));

  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_run && sdo_en) |-> sdo);

  // R2
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READY && sdo_en) |-> !sdo);

  // R5
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (run_cnt == CONV_CYC - 1));

  // R6
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && cs_rise) |=> conv_run);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(int_mode));

  // R10
  ch_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (cur_ch != $past(cur_ch)) && (held_ch == $past(cur_ch)));
endmodule

bind adc_sout_port adc_sout_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .sdo(sdo), .sdo_en(sdo_en),
  .conv_run(conv_run), .conv_done(conv_done), .cur_ch(cur_ch),
  .held_ch(held_ch), .cs_low(cs_low), .cs_rise(cs_rise),
  .cs_fall(cs_fall), .int_mode(int_mode), .fcnt(fcnt)
);

// File: tb/adc_sout_port_test.sv
module adc_sout_port_test;
  localparam int CONV = 40;
  localparam int HALF = 3;
  localparam int XH   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck_in = 1'b1;
  logic        sck_out, sck_drv, sdo, sdo_en, ch_sel;
  logic [27:0] smp_val = '0;
  logic        smp_sgn = 1'b0;
  logic        smp_exr = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] exp_frame;
  logic        exp_ch = 1'b0;

  always #2 clk = ~clk;

  adc_sout_port #(.CONV_CYC(CONV), .SCK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_in),
    .sck_out(sck_out), .sck_drv(sck_drv), .sdo(sdo), .sdo_en(sdo_en),
    .smp_val(smp_val), .smp_sgn(smp_sgn), .smp_exr(smp_exr), .ch_sel(ch_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Set the sample for the conversion now running and predict its frame
  task automatic prime(input logic [27:0] v, input logic s, input logic e);
    smp_val = v; smp_sgn = s; smp_exr = e;
    exp_frame = '0;
    exp_frame[30] = exp_ch;
    exp_frame[29] = s;
    exp_frame[28] = e;
    exp_frame[27:0] = v;
    exp_ch = ~exp_ch;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (sdo !== 1'b0 && n < 20 * CONV) begin
      tick(1);
      n++;
    end
  endtask

  // Externally clocked frame of 32 pulses; returns bits and the line after
  task automatic ext_frame(output logic [31:0] f, output logic after, output bit held_ok);
    held_ok = 1;
    f[31] = sdo;
    for (int k = 1; k <= 32; k++) begin
      sck_in = 1'b1; tick(XH);
      if (sdo !== f[32-k]) held_ok = 0;
      sck_in = 1'b0; tick(XH);
      if (k < 32) f[31-k] = sdo;
    end
    after = sdo;
  endtask

  task automatic take_frame(input string tag);
    logic [31:0] f;
    logic after;
    bit held_ok;
    int n;
    cs_n = 1'b0; tick(XH);
    wait_done(n);
    chk(n < 20 * CONV, "R2 result ready", 32'(n), 32'(CONV));
    ext_frame(f, after, held_ok);
    chk(f === exp_frame, {"R3 frame ", tag}, f, exp_frame);
    chk(f[30] === exp_frame[30], {"R10 channel ", tag}, 32'(f[30]), 32'(exp_frame[30]));
    chk(held_ok, {"R4 bit held across rise ", tag}, 32'(held_ok), 32'd1);
    chk(after === 1'b1, {"R5 line high after last fall ", tag}, 32'(after), 32'd1);
  endtask

  initial begin
    logic [31:0] f;
    logic after;
    bit held_ok;
    int n;

    prime(28'h9ABCDEF, 1'b1, 1'b0);
    sck_in = 1'b1;
    tick(6);
    rst_n = 1'b1;
    tick(2);
    chk(sdo_en === 1'b0, "R1 reset enable", 32'(sdo_en), 32'd0);
    chk(sdo === 1'b0, "R1 reset line", 32'(sdo), 32'd0);
    chk(sck_drv === 1'b1, "R8 power-up internal", 32'(sck_drv), 32'd1);
    chk(ch_sel === 1'b0, "R10 channel 0 first", 32'(ch_sel), 32'd0);

    sck_in = 1'b0; tick(6);
    chk(sck_drv === 1'b1, "R8 level ignored without fall", 32'(sck_drv), 32'd1);

    cs_n = 1'b0; tick(XH);
    chk(sck_drv === 1'b0, "R8 fall selects external", 32'(sck_drv), 32'd0);
    chk(sdo_en === 1'b1 && sdo === 1'b1, "R2 busy flag", 32'(sdo), 32'd1);
    wait_done(n);
    ext_frame(f, after, held_ok);
    chk(f === exp_frame, "R3 first frame", f, exp_frame);
    chk(after === 1'b1, "R5 new conversion flag", 32'(after), 32'd1);
    prime(28'h0000001, 1'b0, 1'b1);
    wait_done(n);
    chk(n >= CONV - 3 && n <= CONV + 1, "R5 conversion length", 32'(n), 32'(CONV - 1));
    ext_frame(f, after, held_ok);
    chk(f === exp_frame, "R3 second frame", f, exp_frame);
    chk(f[30] === 1'b1, "R10 second on channel 1", 32'(f[30]), 32'd1);
    cs_n = 1'b1; tick(XH);

    // walking one over the value with all flag combinations
    for (int i = 0; i < 28; i++) begin
      prime((28'd1 << i) ^ (28'(i) * 28'h0123457), i[0], i[1]);
      take_frame("sweep");
      cs_n = 1'b1; tick(XH);
    end

    // sleep with clock edges while deselected, plus a select blip
    prime(28'h5A5A5A5, 1'b1, 1'b1);
    tick(3 * CONV);
    for (int k = 0; k < 20; k++) begin
      sck_in = 1'b1; tick(XH); sck_in = 1'b0; tick(XH);
    end
    chk(sdo_en === 1'b0 && sdo === 1'b0, "R1 quiet while deselected", 32'(sdo), 32'd0);
    cs_n = 1'b0; tick(XH);
    chk(sdo === 1'b0, "R7 result held in sleep", 32'(sdo), 32'd0);
    cs_n = 1'b1; tick(XH);
    cs_n = 1'b0; tick(XH);
    chk(sdo === 1'b0, "R7 blip keeps result", 32'(sdo), 32'd0);
    ext_frame(f, after, held_ok);
    chk(f === exp_frame, "R1 frame intact after ignored clocks", f, exp_frame);
    cs_n = 1'b1; tick(XH);

    // abort in the middle of a frame
    prime(28'h0F0F0F0, 1'b0, 1'b0);
    cs_n = 1'b0; tick(XH);
    wait_done(n);
    for (int k = 0; k < 10; k++) begin
      sck_in = 1'b1; tick(XH); sck_in = 1'b0; tick(XH);
    end
    chk(sdo === exp_frame[21], "R4 partial frame bit", 32'(sdo), 32'(exp_frame[21]));
    cs_n = 1'b1; tick(XH);
    prime(28'hFEDCBA9, 1'b1, 1'b0);
    cs_n = 1'b0; tick(XH);
    chk(sdo === 1'b1, "R6 abort restarts conversion", 32'(sdo), 32'd1);
    cs_n = 1'b1; tick(XH);
    take_frame("after abort");
    cs_n = 1'b1; tick(XH);

    // internal clock mode, two frames
    for (int r = 0; r < 2; r++) begin
      logic prev;
      int rises;
      int t_first;
      int t_second;
      int cyc;
      prime(r == 0 ? 28'hC3C3C3C : 28'h1234567, r[0], ~r[0]);
      sck_in = 1'b1; tick(XH);
      cs_n = 1'b0; tick(XH);
      chk(sck_drv === 1'b1, "R8 fall selects internal", 32'(sck_drv), 32'd1);
      f = '0; rises = 0; cyc = 0; prev = sck_out; t_first = 0; t_second = 0;
      while (rises < 32 && cyc < 20 * CONV) begin
        tick(1); cyc++;
        if (sck_out && !prev) begin
          f[31-rises] = sdo;
          if (rises == 0) t_first = cyc;
          if (rises == 1) t_second = cyc;
          rises++;
        end
        prev = sck_out;
      end
      chk(rises == 32, "R9 pulse count", 32'(rises), 32'd32);
      chk(t_second - t_first == 2 * HALF, "R9 clock period", 32'(t_second - t_first), 32'(2 * HALF));
      chk(f === exp_frame, "R9 internal frame", f, exp_frame);
      tick(HALF + 2);
      chk(sdo === 1'b1, "R5 internal end starts conversion", 32'(sdo), 32'd1);
      cs_n = 1'b1; tick(XH);
    end

    sck_in = 1'b0; tick(XH);
    cs_n = 1'b0; tick(XH);
    chk(sck_drv === 1'b0, "R8 back to external", 32'(sck_drv), 32'd0);
    cs_n = 1'b1; tick(XH);
    prime(28'h7777777, 1'b0, 1'b1);
    take_frame("final");
    cs_n = 1'b1; tick(XH);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule